// File: doc/BRIEF.md
# Presence-Detect Serial EEPROM Slave

This block is the serial slave side of a small identification memory that sits on a two-wire bus (I2C). It holds 256 bytes. By convention the low half stores identification data and the high half is free for the user. The block oversamples the bus clock (SCL) and data (SDA) lines with the system clock. It finds start and stop conditions and decodes a 7-bit device address. That address is made of a fixed 4-bit type code and three strap inputs, so eight of these slaves can share one bus.

A master writes by sending the device address with the read/write bit low, then a word address, then any number of data bytes. The internal pointer steps through memory and wraps. A master reads from the current pointer by sending the device address with the read/write bit high. For a random read, it first writes a word address and then issues a repeated start. The master's acknowledge after each read byte decides whether the slave sends another byte. A write-protect input blocks storage without changing the bus handshake. The block drives only an SDA pull-down enable and a standby flag; the open-drain pad is outside it.

Top module: `spd_eeprom_slave`

## Requirements
- R1: While reset is asserted and in the cycle after it, `standby` is 1 and `sda_pull` is 0.
- R2: Until the first start condition (SDA falling while SCL is high), clocked bus traffic gets no acknowledge and `standby` stays 1.
- R3: The first byte after a start is the device address `{1010, strap[2:0], rw}`, sent MSB first, with rw=1 meaning read. The slave acknowledges it (pulls SDA low during the ninth SCL pulse) only when the upper seven bits match. On a mismatch it stays silent until the next start or stop.
- R4: In a write, the byte after the device address sets the word pointer. Each following data byte is stored at the pointer, and every byte is acknowledged.
- R5: The pointer increments after each stored or sent byte and wraps from 255 to 0.
- R6: A read that starts right after a start and the read address returns the byte at the current pointer, which is the last write or read position plus one.
- R7: In a read, a master acknowledge (SDA low on the ninth pulse) makes the slave send the next byte. This continues across the 255-to-0 wrap.
- R8: After a master non-acknowledge (SDA high on the ninth pulse), the slave releases SDA and keeps it released through any further SCL pulses until a start or stop.
- R9: A stop condition (SDA rising while SCL is high) sets `standby` to 1. A start sets it to 0. While `standby` is 1, `sda_pull` is 0.
- R10: While `wp` is 1, data bytes are still acknowledged but memory is not changed.
- R11: A repeated start in the middle of a write restarts the address phase, so a word-address write followed by a read address gives a random read.
- R12: `sda_pull` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| strap | input | 3 | Device address select straps |
| wp | input | 1 | Write protect, 1 blocks stores |
| sda_pull | output | 1 | 1 pulls the data line low |
| standby | output | 1 | 1 when the slave is idle after a stop or reset |

## Verification
Two events can fall in the same SCL-high window: the sampling edge of a data bit and a start condition. In a repeated start, SCL rises while SDA is high and the slave clocks that bit into its write-data shift register. SDA then falls with SCL still high, and the slave must discard the partial byte and begin address decoding. The bench provokes this by sending a repeated start straight after a word-address byte. The outcome is judged by whether the read address that follows is acknowledged, and whether the returned bytes come from the word address just written and not from a corrupted pointer or a stored stray byte.

// File: rtl/spd_eeprom_slave.sv
module spd_eeprom_slave #(
  parameter int          AW       = 8,
  parameter logic [3:0]  DEV_TYPE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl,
  input  logic       sda_i,
  input  logic [2:0] strap,
  input  logic       wp,
  output logic       sda_pull,
  output logic       standby
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WADR, S_WDAT, S_READ, S_WAIT} st_t;

  logic [2:0]    scl_q, sda_q;
  st_t           st;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic [AW-1:0] ptr;
  logic          ackph, rw, mack, pull, stby;
  logic [7:0]    mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  wire s_scl  = scl_q[1];
  wire p_scl  = scl_q[2];
  wire s_sda  = sda_q[1];
  wire p_sda  = sda_q[2];
  wire start  = p_scl & s_scl & p_sda & ~s_sda;
  wire stop   = p_scl & s_scl & ~p_sda & s_sda;
  wire rise   = ~p_scl & s_scl;
  wire fall   = p_scl & ~s_scl;
  wire full   = (bitcnt == 4'd8);
  wire [7:0] rdata = mem[ptr];
  wire addr_hit = (shreg[7:1] == {DEV_TYPE, strap});
  wire wr_en  = (st == S_WDAT) & fall & ~ackph & full & ~wp;

  always_ff @(posedge clk) begin
    if (wr_en) mem[ptr] <= shreg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      ptr    <= '0;
      ackph  <= 1'b0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      pull   <= 1'b0;
      stby   <= 1'b1;
    end else if (start) begin
      st     <= S_ADDR;
      bitcnt <= '0;
      ackph  <= 1'b0;
      pull   <= 1'b0;
      stby   <= 1'b0;
    end else if (stop) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      ackph  <= 1'b0;
      pull   <= 1'b0;
      stby   <= 1'b1;
    end else begin
      case (st)
        S_ADDR, S_WADR, S_WDAT: begin
          if (rise && !ackph && !full) begin
            shreg  <= {shreg[6:0], s_sda};
            bitcnt <= bitcnt + 4'd1;
          end else if (fall && ackph) begin
            ackph  <= 1'b0;
            pull   <= 1'b0;
            bitcnt <= '0;
            if (st == S_ADDR && rw) begin
              st    <= S_READ;
              shreg <= rdata;
              ptr   <= ptr + 1'b1;
              pull  <= ~rdata[7];
            end else if (st == S_ADDR) begin
              st <= S_WADR;
            end else begin
              st <= S_WDAT;
            end
          end else if (fall && full) begin
            if (st == S_ADDR) begin
              if (addr_hit) begin
                rw    <= shreg[0];
                ackph <= 1'b1;
                pull  <= 1'b1;
              end else begin
                st <= S_WAIT;
              end
            end else begin
              ackph <= 1'b1;
              pull  <= 1'b1;
              if (st == S_WADR) ptr <= shreg[AW-1:0];
              else              ptr <= ptr + 1'b1;
            end
          end
        end
        S_READ: begin
          if (rise && !ackph) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (rise) begin
            mack <= ~s_sda;
          end else if (fall && !ackph && !full) begin
            shreg <= {shreg[6:0], 1'b0};
            pull  <= ~shreg[6];
          end else if (fall && !ackph) begin
            pull  <= 1'b0;
            ackph <= 1'b1;
          end else if (fall) begin
            ackph  <= 1'b0;
            bitcnt <= '0;
            if (mack) begin
              shreg <= rdata;
              ptr   <= ptr + 1'b1;
              pull  <= ~rdata[7];
            end else begin
              st   <= S_WAIT;
              pull <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull = pull;
  assign standby  = stby;
endmodule

module spd_eeprom_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl,
  input logic sda_pull,
  input logic standby
);
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (standby && !sda_pull));

  a_r12_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl);

  a_r9_standby_silent: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !sda_pull);

  a_r9_standby_edge_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(standby) || $fell(standby)) |-> scl);
endmodule

bind spd_eeprom_slave spd_eeprom_slave_chk u_chk (.*);

// File: tb/test_spd_eeprom_slave.sv
module test_spd_eeprom_slave;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic       sda_pull, standby;
  logic       sda_bus;

  assign sda_bus = m_sda & ~sda_pull;

  always #10 clk = ~clk;

  spd_eeprom_slave i_spd_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl(m_scl), .sda_i(sda_bus),
    .strap(strap), .wp(wp), .sda_pull(sda_pull), .standby(standby));

  localparam int Q = 8;
  int checks = 0;
  int errors = 0;
  int exp_mem [256];
  bit done = 1'b0;

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ref_wr(input int a, input int d);
    if (!wp) exp_mem[a % 256] = d;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q(); q();
  endtask

  task automatic clk_bit(input bit b, output bit r);
    m_sda = b; q(); m_scl = 1'b1; q(); r = sda_bus; q(); m_scl = 1'b0; q();
  endtask

  task automatic send_byte(input int b, input int exp_ack, input string tag);
    bit r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    check(tag, int'(!r), exp_ack);
  endtask

  task automatic recv_byte(input int exp, input bit mack, input string tag);
    int v;
    bit r;
    v = 0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, r);
      v = (v << 1) | int'(r);
    end
    check(tag, v, exp);
    clk_bit(!mack, r);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      finish_run();
    end
  end

  initial begin
    bit r;
    for (int i = 0; i < 256; i++) exp_mem[i] = 0;
    repeat (4) @(negedge clk);
    check("R1 standby in reset", int'(standby), 1);
    check("R1 pull in reset", int'(sda_pull), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 standby after reset", int'(standby), 1);
    check("R1 pull after reset", int'(sda_pull), 0);
    q();

    // R2: matching address clocked without any start
    m_scl = 1'b0; q();
    send_byte(8'hAA, 0, "R2 no ack before start");
    m_scl = 1'b1; q();
    check("R2 still standby", int'(standby), 1);

    // R3: wrong strap and wrong type code are not acknowledged
    bus_start();
    check("R9 start clears standby", int'(standby), 0);
    send_byte(8'hA0, 0, "R3 strap mismatch");
    send_byte(8'hAA, 0, "R3 silent after mismatch");
    bus_stop();
    check("R9 stop sets standby", int'(standby), 1);
    bus_start();
    send_byte(8'hEA, 0, "R3 type mismatch");
    bus_stop();

    // R4, R5: write two bytes at 0x10
    bus_start();
    send_byte(8'hAA, 1, "R3 address match");
    send_byte(8'h10, 1, "R4 word address ack");
    send_byte(8'h5C, 1, "R4 data ack");
    ref_wr(16, 8'h5C);
    send_byte(8'hA7, 1, "R5 second data ack");
    ref_wr(17, 8'hA7);
    bus_stop();

    // R5: sequential write across the wrap
    bus_start();
    send_byte(8'hAA, 1, "R3 address match");
    send_byte(8'hFE, 1, "R4 word address ack");
    send_byte(8'h11, 1, "R5 data ack");   ref_wr(254, 8'h11);
    send_byte(8'h22, 1, "R5 data ack");   ref_wr(255, 8'h22);
    send_byte(8'h33, 1, "R5 wrap data ack"); ref_wr(256, 8'h33);

    // R11: repeated start right after the word address
    bus_stop();
    bus_start();
    send_byte(8'hAA, 1, "R3 address match");
    send_byte(8'hFE, 1, "R11 word address ack");
    bus_start();
    send_byte(8'hAB, 1, "R11 read address after repeated start");
    recv_byte(exp_mem[254], 1'b1, "R7 first read byte");
    recv_byte(exp_mem[255], 1'b1, "R7 second read byte");
    recv_byte(exp_mem[0], 1'b0, "R7 R5 read across wrap");
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, r);
      check("R8 released after nack", int'(r), 1);
    end
    check("R8 not standby before stop", int'(standby), 0);
    bus_stop();
    check("R9 standby after read", int'(standby), 1);

    // R6: current address reads
    bus_start();
    send_byte(8'hAA, 1, "R3 address match");
    send_byte(8'h10, 1, "R6 set pointer");
    bus_stop();
    bus_start();
    send_byte(8'hAB, 1, "R6 read address ack");
    recv_byte(exp_mem[16], 1'b0, "R6 current read");
    bus_stop();
    bus_start();
    send_byte(8'hAB, 1, "R6 read address ack");
    recv_byte(exp_mem[17], 1'b0, "R6 current read advanced");
    bus_stop();

    // R10: write protect
    wp = 1'b1;
    bus_start();
    send_byte(8'hAA, 1, "R3 address match");
    send_byte(8'h10, 1, "R10 word address ack");
    send_byte(8'h99, 1, "R10 protected data ack");
    ref_wr(16, 8'h99);
    bus_stop();
    wp = 1'b0;
    bus_start();
    send_byte(8'hAA, 1, "R3 address match");
    send_byte(8'h10, 1, "R10 word address ack");
    bus_start();
    send_byte(8'hAB, 1, "R11 read address ack");
    recv_byte(exp_mem[16], 1'b0, "R10 protected byte unchanged");
    bus_stop();
    check("R9 final standby", int'(standby), 1);
    check("R12 pull idle", int'(sda_pull), 0);

    done = 1'b1;
    finish_run();
  end
endmodule